// File: doc/BRIEF.md
# SPI Master/Slave Serial Port

This block moves words between a parallel push/pop interface and a four-wire SPI bus. It can act as bus master or as bus slave. Software-side logic pushes words into a transmit queue and pops received words from a receive queue. Each queue holds eight 16-bit entries. Both the frame length (4 to 16 bits) and the SPI mode (clock idle level and sampling edge) come from static configuration inputs.

In master mode the block makes its own serial clock. A prescaler divides the system clock, and a divider further divides that result. The block drives the active-low select for as long as a frame is in flight. In slave mode it follows an external clock and an external select, which it brings into its own clock domain before use.

A loopback switch routes the serial output straight back to the serial input. An enable input stops all shifting. Three maskable interrupt outputs report:
- transmit queue running low,
- receive queue filling,
- a receive overrun.

Top module: `spi_port`

## Requirements
- R1: After reset, ss_n_o is 1, sclk_o equals cfg_cpol, tx_empty and rx_empty are 1, and with cfg_irq_mask = 0 all three interrupts are 0.
- R2: The transmit queue holds 8 words. While tx_full is 1, a tx_push is dropped, and the dropped word is never sent.
- R3: In master mode with cfg_en = 1, every queued word is sent as one frame, most significant bit first, with ss_n_o held low for the whole frame. With cfg_loop = 1 the received word equals the sent word.
- R4: All four combinations of cfg_cpol and cfg_cpha transfer data correctly. sclk_o rests at cfg_cpol whenever no frame is active. With cfg_cpha = 0 data is sampled on the first clock edge of each bit; with cfg_cpha = 1 it is sampled on the second.
- R5: The frame length is cfg_width + 1 bits, with cfg_width ranging from 3 to 15. A received word sits in the low bits with zeros above. Transmit bits above the frame length are ignored.
- R6: In master mode each half period of sclk_o lasts (cfg_prescale/2) × (cfg_divider + 1) system clocks. cfg_prescale takes even values from 2 to 254.
- R7: While cfg_en = 0, no frame runs, ss_n_o stays 1, queued transmit words stay queued, and any frame in flight is abandoned.
- R8: A frame that finishes while the receive queue is full is discarded and the stored words are kept. It also sets an overrun flag, which stays set until an ovr_clr pulse.
- R9: irq_tx = cfg_irq_mask[0] and (transmit level ≤ 4). irq_rx = cfg_irq_mask[1] and (receive level ≥ 4). irq_ovr = cfg_irq_mask[2] and the overrun flag.
- R10: In slave mode, ss_n_i low starts a frame clocked by sclk_i. The slave sends the head transmit word, or zeros if the queue is empty, and receives into the receive queue. A rising ss_n_i abandons a partial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enables serial operation |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_loop | input | 1 | Internal loopback of serial output to input |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0 = sample on first edge, 1 = sample on second edge |
| cfg_width | input | 4 | Frame length minus one (3..15) |
| cfg_prescale | input | 8 | Even prescale value 2..254 |
| cfg_divider | input | 8 | Bit-rate divider, divides by value + 1 |
| cfg_irq_mask | input | 3 | Interrupt enables: [0] tx, [1] rx, [2] overrun |
| tx_push | input | 1 | Write tx_data into the transmit queue |
| tx_data | input | 16 | Word to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Remove the head receive word |
| rx_data | output | 16 | Head receive word |
| rx_empty | output | 1 | Receive queue empty |
| ovr_clr | input | 1 | Clears the overrun flag |
| irq_tx | output | 1 | Transmit queue low interrupt |
| irq_rx | output | 1 | Receive queue filling interrupt |
| irq_ovr | output | 1 | Receive overrun interrupt |
| sclk_o | output | 1 | Master serial clock |
| ss_n_o | output | 1 | Master active-low select |
| ser_out | output | 1 | Serial data out |
| ser_in | input | 1 | Serial data in |
| sclk_i | input | 1 | Slave serial clock |
| ss_n_i | input | 1 | Slave active-low select |

## Verification
The embedded assertions depend on some inputs staying steady:
- The configuration inputs do not change while a frame is active.
- cfg_cpol does not change in the cycle before an idle clock level is checked.
- In slave mode, every level of sclk_i and ss_n_i lasts at least three system clocks, so the two-flop synchroniser can catch each edge.

The stimulus respects these limits. It changes configuration only after the scoreboard queue has drained and the select is high. In the slave test it holds each half period of the external clock for eight system clocks and waits eight clocks after lowering the select.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int WORD_W     = 16;
  localparam int IDX_W      = $clog2(WORD_W);
  localparam int FIFO_DEPTH = 8;
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
  localparam int HALF_LVL   = FIFO_DEPTH / 2;
  localparam int MIN_WIDTH  = 3;
  localparam int SYNC_W     = 2;
endpackage

// File: rtl/spi_port_fifo.sv
module spi_port_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_d;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = do_push ? AW'(wp_q + 1'b1) : wp_q;
    rp_d  = do_pop  ? AW'(rp_q + 1'b1) : rp_q;
    cnt_d = count;
    if (do_push && !do_pop) cnt_d = count + 1'b1;
    if (do_pop && !do_push) cnt_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      count <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (count == $past(count)));
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       cpol,
  input  logic [7:0] prescale,
  input  logic [7:0] divider,
  output logic       sclk,
  output logic       lead,
  output logic       trail
);
  logic [6:0] pre_q, pre_d, pre_last, pre_half;
  logic [7:0] div_q, div_d;
  logic       sclk_d, pre_wrap, tick;

  assign pre_half = 7'(prescale >> 1);
  assign pre_last = (pre_half == 7'd0) ? 7'd0 : pre_half - 7'd1;
  assign pre_wrap = (pre_q == pre_last);
  assign tick     = run & pre_wrap & (div_q == divider);
  assign lead     = tick & (sclk == cpol);
  assign trail    = tick & (sclk != cpol);

  always_comb begin
    pre_d  = pre_q;
    div_d  = div_q;
    sclk_d = sclk;
    if (!run) begin
      pre_d  = '0;
      div_d  = '0;
      sclk_d = cpol;
    end else begin
      pre_d = pre_wrap ? 7'd0 : pre_q + 7'd1;
      if (pre_wrap) div_d = (div_q == divider) ? 8'd0 : div_q + 8'd1;
      if (tick) sclk_d = ~sclk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
      sclk  <= 1'b0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
      sclk  <= sclk_d;
    end
  end

  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run) && $stable(cpol)) |-> (sclk == cpol));
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter import spi_port_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              abort,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [IDX_W-1:0]  width_m1,
  input  logic              cpha,
  input  logic              lead,
  input  logic              trail,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] txsh_q, txsh_d, rxsh_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic              busy_d, done_d, last_bit;

  assign last_bit = (bidx_q == width_m1);
  assign ser_out  = txsh_q[width_m1];

  always_comb begin
    txsh_d = txsh_q;
    rxsh_d = rx_word;
    bidx_d = bidx_q;
    busy_d = busy;
    done_d = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
    end else if (load) begin
      busy_d = 1'b1;
      txsh_d = tx_word;
      rxsh_d = '0;
      bidx_d = '0;
    end else if (busy) begin
      if (lead) begin
        if (!cpha) rxsh_d = {rx_word[WORD_W-2:0], ser_in};
        else if (bidx_q != '0) txsh_d = txsh_q << 1;
      end
      if (trail) begin
        if (cpha) rxsh_d = {rx_word[WORD_W-2:0], ser_in};
        if (last_bit) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bidx_d = bidx_q + 1'b1;
          if (!cpha) txsh_d = txsh_q << 1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh_q  <= '0;
      rx_word <= '0;
      bidx_q  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      txsh_q  <= txsh_d;
      rx_word <= rxsh_d;
      bidx_q  <= bidx_d;
      busy    <= busy_d;
      done    <= done_d;
    end
  end

  p_done_ends_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/spi_port.sv
module spi_port import spi_port_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_master,
  input  logic              cfg_loop,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [IDX_W-1:0]  cfg_width,
  input  logic [7:0]        cfg_prescale,
  input  logic [7:0]        cfg_divider,
  input  logic [2:0]        cfg_irq_mask,
  input  logic              tx_push,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_pop,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_empty,
  input  logic              ovr_clr,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_ovr,
  output logic              sclk_o,
  output logic              ss_n_o,
  output logic              ser_out,
  input  logic              ser_in,
  input  logic              sclk_i,
  input  logic              ss_n_i
);
  logic [SYNC_W-1:0] rst_pipe;
  logic              rst_int;
  logic [SYNC_W:0]   sclk_sync;
  logic [SYNC_W-1:0] ss_sync;
  logic              ovr_q, ovr_d;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl;
  logic [WORD_W-1:0] tx_head, rx_word, load_word;
  logic [IDX_W-1:0]  width_eff;
  logic              busy, done, start, abort, tx_pop, rx_push, rx_full;
  logic              m_lead, m_trail, s_edge, s_lead, s_trail, lead, trail;
  logic              ss_int, ser_in_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_W-2:0], 1'b1};
  end
  assign rst_int = rst_pipe[SYNC_W-1];

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      sclk_sync <= '0;
      ss_sync   <= '1;
      ovr_q     <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_W-1:0], sclk_i};
      ss_sync   <= {ss_sync[SYNC_W-2:0], ss_n_i};
      ovr_q     <= ovr_d;
    end
  end

  assign ss_int     = ss_sync[SYNC_W-1];
  assign s_edge     = sclk_sync[SYNC_W] ^ sclk_sync[SYNC_W-1];
  assign s_lead     = s_edge & (sclk_sync[SYNC_W-1] != cfg_cpol);
  assign s_trail    = s_edge & (sclk_sync[SYNC_W-1] == cfg_cpol);
  assign lead       = cfg_master ? m_lead  : s_lead;
  assign trail      = cfg_master ? m_trail : s_trail;
  assign width_eff  = (cfg_width < IDX_W'(MIN_WIDTH)) ? IDX_W'(MIN_WIDTH) : cfg_width;
  assign ser_in_eff = cfg_loop ? ser_out : ser_in;

  always_comb begin
    start = 1'b0;
    abort = 1'b0;
    if (cfg_en && !busy) start = cfg_master ? !tx_empty : !ss_int;
    if (busy) abort = !cfg_en || (!cfg_master && ss_int);
    tx_pop    = start && !tx_empty;
    load_word = tx_empty ? '0 : tx_head;
    rx_push   = done && !rx_full;
    ovr_d     = ovr_clr ? 1'b0 : ovr_q;
    if (done && rx_full) ovr_d = 1'b1;
  end

  assign ss_n_o  = !(busy && cfg_master);
  assign irq_tx  = cfg_irq_mask[0] && (tx_lvl <= LVL_W'(HALF_LVL));
  assign irq_rx  = cfg_irq_mask[1] && (rx_lvl >= LVL_W'(HALF_LVL));
  assign irq_ovr = cfg_irq_mask[2] && ovr_q;

  spi_port_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_int), .push(tx_push), .din(tx_data), .pop(tx_pop),
    .dout(tx_head), .count(tx_lvl), .full(tx_full), .empty(tx_empty));

  spi_port_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_int), .push(rx_push), .din(rx_word), .pop(rx_pop),
    .dout(rx_data), .count(rx_lvl), .full(rx_full), .empty(rx_empty));

  spi_port_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_int), .run(busy && cfg_master), .cpol(cfg_cpol),
    .prescale(cfg_prescale), .divider(cfg_divider),
    .sclk(sclk_o), .lead(m_lead), .trail(m_trail));

  spi_port_shifter u_shift (
    .clk(clk), .rst_n(rst_int), .load(start), .abort(abort), .tx_word(load_word),
    .width_m1(width_eff), .cpha(cfg_cpha), .lead(lead), .trail(trail),
    .ser_in(ser_in_eff), .ser_out(ser_out), .busy(busy), .done(done),
    .rx_word(rx_word));

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_int)
    !cfg_en |=> ss_n_o);
  p_ovr_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(ovr_q) |-> $past(rx_full));
  p_rx_keeps_full_r8: assert property (@(posedge clk) disable iff (!rst_int)
    (rx_full && !rx_pop) |=> rx_full);
endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_master = 1'b1, cfg_loop = 1'b1;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [3:0]  cfg_width = 4'd7;
  logic [7:0]  cfg_prescale = 8'd2, cfg_divider = 8'd1;
  logic [2:0]  cfg_irq_mask = 3'b000;
  logic        tx_push = 1'b0, rx_pop = 1'b0, ovr_clr = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_full, tx_empty, rx_empty, irq_tx, irq_rx, irq_ovr;
  logic [15:0] rx_data;
  logic        sclk_o, ss_n_o, ser_out;
  logic        ser_in = 1'b0, sclk_i = 1'b0, ss_n_i = 1'b1;

  int n_cmp = 0, n_bad = 0;
  bit mon_on = 1'b0;
  logic [15:0] expq[$];

  always #5 clk = ~clk;

  spi_port u_spi_port (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Scoreboard monitor: pop and compare each received word
  initial forever begin
    @(negedge clk);
    rx_pop = 1'b0;
    if (mon_on && !rx_empty) begin
      if (expq.size() == 0) check(1'b0, "R3 unexpected word", rx_data, 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        check(rx_data == e, "R3/R4/R5 received word", rx_data, e);
      end
      rx_pop = 1'b1;
    end
  end

  // Driver: queue word for transmit and record expected receive value
  task automatic send(input logic [15:0] w, input bit expect_it);
    logic [15:0] m;
    m = 16'hFFFF >> (15 - cfg_width);
    @(negedge clk);
    tx_push = 1'b1;
    tx_data = w;
    if (expect_it) expq.push_back(w & m);
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic drain(input string req);
    int t = 0;
    while ((expq.size() != 0 || !ss_n_o) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(ss_n_o == 1'b1, "R1 ss_n_o", ss_n_o, 1);
    check(sclk_o == 1'b0, "R1 sclk_o", sclk_o, 0);
    check(tx_empty && rx_empty, "R1 queues empty", {tx_empty, rx_empty}, 2'b11);
    check({irq_tx, irq_rx, irq_ovr} == 3'b000, "R1 irqs masked", {irq_tx, irq_rx, irq_ovr}, 0);

    cfg_irq_mask = 3'b111;
    mon_on = 1'b1;
    // R2 and R7: disabled, nine pushes, ninth dropped, nothing shifted
    for (int i = 0; i < 9; i++) send(16'h0011 * 16'(i + 1), i < 8);
    check(tx_full == 1'b1, "R2 tx_full", tx_full, 1);
    repeat (100) @(negedge clk);
    check(rx_empty && ss_n_o && !tx_empty, "R7 idle while disabled",
          {rx_empty, ss_n_o, tx_empty}, 3'b110);
    check(irq_tx == 1'b0, "R9 irq_tx with 8 queued", irq_tx, 0);
    cfg_en = 1'b1;
    drain("R2 eight words received");
    check(irq_tx == 1'b1, "R9 irq_tx when empty", irq_tx, 1);

    // R4 all modes, loopback master
    for (int md = 0; md < 4; md++) begin
      cfg_cpol = md[1];
      cfg_cpha = md[0];
      repeat (4) @(negedge clk);
      check(sclk_o == cfg_cpol, "R4 idle sclk level", sclk_o, cfg_cpol);
      send(16'h00A5, 1'b1);
      send(16'h003C, 1'b1);
      send(16'h0081, 1'b1);
      drain("R4 mode drained");
    end
    cfg_cpol = 1'b0;
    cfg_cpha = 1'b0;

    // R5 widths: upper transmit bits ignored, receive right-justified
    cfg_width = 4'd3;
    send(16'hFFF9, 1'b1);
    send(16'h1236, 1'b1);
    drain("R5 4-bit frames");
    cfg_width = 4'd15;
    send(16'hBEEF, 1'b1);
    send(16'h8001, 1'b1);
    drain("R5 16-bit frames");
    cfg_width = 4'd7;

    // R6 bit period: prescale 4, divider 2 -> 12 clocks per bit
    cfg_prescale = 8'd4;
    cfg_divider  = 8'd2;
    begin
      longint t0, t1;
      send(16'h0055, 1'b1);
      @(posedge sclk_o); t0 = $time;
      @(posedge sclk_o); t1 = $time;
      check((t1 - t0) == 120, "R6 period 12 clocks", 32'(t1 - t0), 120);
      drain("R6 drained");
      cfg_prescale = 8'd6;
      cfg_divider  = 8'd0;
      send(16'h0055, 1'b1);
      @(posedge sclk_o); t0 = $time;
      @(posedge sclk_o); t1 = $time;
      check((t1 - t0) == 60, "R6 period 6 clocks", 32'(t1 - t0), 60);
      drain("R6 drained 2");
    end
    cfg_prescale = 8'd2;
    cfg_divider  = 8'd0;

    // R8 overrun: fill rx with monitor off, ninth frame dropped
    mon_on = 1'b0;
    for (int i = 0; i < 9; i++) begin
      send(16'h00C0 + 16'(i), 1'b1);
      repeat (30) @(negedge clk);
    end
    repeat (50) @(negedge clk);
    check(irq_ovr == 1'b1, "R8 overrun flagged", irq_ovr, 1);
    check(irq_rx == 1'b1, "R9 irq_rx with full queue", irq_rx, 1);
    void'(expq.pop_back());
    mon_on = 1'b1;
    drain("R8 stored words kept");
    check(irq_rx == 1'b0, "R9 irq_rx after drain", irq_rx, 0);
    check(irq_ovr == 1'b1, "R8 flag sticky", irq_ovr, 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    @(negedge clk);
    check(irq_ovr == 1'b0, "R8 flag cleared", irq_ovr, 0);
    cfg_irq_mask = 3'b000;
    @(negedge clk);
    check(irq_tx == 1'b0, "R9 mask clears irq_tx", irq_tx, 0);

    // R10 slave mode, mode 0, external clock with 8-cycle half periods
    cfg_master = 1'b0;
    cfg_loop   = 1'b0;
    send(16'h00A5, 1'b0);
    expq.push_back(16'h003C);
    begin
      logic [7:0] got;
      logic [7:0] drv;
      drv = 8'h3C;
      got = '0;
      ss_n_i = 1'b0;
      repeat (8) @(negedge clk);
      for (int b = 7; b >= 0; b--) begin
        ser_in = drv[b];
        repeat (8) @(negedge clk);
        got = {got[6:0], ser_out};
        sclk_i = 1'b1;
        repeat (8) @(negedge clk);
        sclk_i = 1'b0;
        repeat (8) @(negedge clk);
      end
      ss_n_i = 1'b1;
      check(got == 8'hA5, "R10 slave output bits", got, 8'hA5);
    end
    drain("R10 slave received");
    check(tx_empty == 1'b1, "R10 slave consumed word", tx_empty, 1);
    summary();
  end
endmodule